// File: doc/BRIEF.md
# Status Register and Write-Protection Guard

This block is the control core of a serial nonvolatile memory. It keeps the status byte, the write-enable latch and the two-bit protection code. It decides whether a requested array write may proceed and runs a timed write cycle. Commands reach it already decoded, as single-cycle pulses: set the latch, clear the latch, write the status byte with a data byte, and write to an array address. Serial shifting happens elsewhere.

An accepted write starts an internal cycle. The cycle lasts a parameterised number of clocks, and the busy flag is high for the whole of it. During the cycle the status byte reads as all ones, and every new command is ignored. When the cycle ends, the enable latch clears by itself. A write is refused when the latch is clear or when the address lies in the protected upper region. A refused write starts no cycle and leaves every state bit unchanged.

Top module: `stsreg_guard`

## Requirements
- R1: When idle, `status_byte` is {wpen, 3'b000, bp[1], bp[0], wel, 1'b0}. Bit 7 is the write-protect-enable flag, bits 3:2 are the protection code, bit 1 is the enable latch and bit 0 is the busy flag. Reset clears wpen, bp and wel, so the reset value is 8'h00.
- R2: `cmd_set_wel` sets the latch and `cmd_clr_wel` clears it; the change is visible one clock later. If both are pulsed in the same cycle, the latch ends cleared.
- R3: `wr_permit` is high only when the latch is set, the block is not busy and `write_addr` is unprotected. The protection code maps as follows: 00 protects nothing, 01 protects 0x1800-0x1FFF, 10 protects 0x1000-0x1FFF, and 11 protects the whole array (defaults, ADDR_W=13).
- R4: A `cmd_write` pulse with `wr_permit` high sets `busy` from the next clock, and `busy` stays high for exactly CYCLE_CLKS clocks.
- R5: While `busy` is high, `status_byte` reads 8'hFF.
- R6: When a write cycle of either kind ends, the enable latch is clear.
- R7: A refused write (latch clear or address protected) leaves `busy` low and the latch unchanged.
- R8: A status write needs the latch set and ignores protection. It copies data bit 7 to wpen and data bits 3:2 to bp, ignores data bits 6:4 and 1:0, and starts a cycle like an array write.
- R9: While `busy` is high, set, clear, status-write and write commands have no effect.
- R10: When several commands arrive in one cycle, only the highest-priority one acts. The priority order is write, then status write, then clear, then set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_set_wel | input | 1 | Pulse: set the enable latch |
| cmd_clr_wel | input | 1 | Pulse: clear the enable latch |
| cmd_wrsr | input | 1 | Pulse: write the status byte from `wrsr_data` |
| wrsr_data | input | 8 | Data byte for a status write |
| cmd_write | input | 1 | Pulse: request an array write at `write_addr` |
| write_addr | input | ADDR_W | Array address for the write and for the permit decision |
| status_byte | output | 8 | Status byte as returned by a status read |
| busy | output | 1 | Write cycle in progress |
| wr_permit | output | 1 | A write to `write_addr` would be accepted now |

## Verification
The bench keeps ADDR_W=13 and overrides CYCLE_CLKS to 4. With this short cycle, the exact busy length, the all-ones status read on every busy clock and the latch clearing at cycle end can each be checked clock by clock, and many cycles fit in a short run. The 13-bit address is kept so that every protection boundary, 0x0FFF/0x1000, 0x17FF/0x1800 and 0x1FFF, can be driven on either side.

// File: rtl/stsreg_pkg.sv
package stsreg_pkg;

  typedef enum logic [2:0] {
    OP_NONE  = 3'd0,
    OP_WRITE = 3'd1,
    OP_WRSR  = 3'd2,
    OP_CLR   = 3'd3,
    OP_SET   = 3'd4
  } op_e;

  typedef struct packed {
    logic       wpen;
    logic [1:0] bp;
  } nvbits_t;

  // Lowest protected address for a code; span = array size in bytes.
  function automatic logic region_locked(logic [1:0] bp, int unsigned addr,
                                         int unsigned span);
    int unsigned base;
    case (bp)
      2'b01:   base = span - span / 4;
      2'b10:   base = span / 2;
      2'b11:   base = 0;
      default: base = span;
    endcase
    return addr >= base;
  endfunction

  function automatic logic [7:0] status_view(logic busy, nvbits_t nv, logic wel);
    if (busy) return 8'hFF;
    return {nv.wpen, 3'b000, nv.bp, wel, 1'b0};
  endfunction

endpackage

// File: rtl/stsreg_arb.sv
module stsreg_arb
  import stsreg_pkg::*;
(
  input  logic cmd_set_wel,
  input  logic cmd_clr_wel,
  input  logic cmd_wrsr,
  input  logic cmd_write,
  input  logic busy,
  input  logic wel,
  input  logic locked,
  output op_e  op,
  output logic start,
  output logic permit
);

  always_comb begin
    op = OP_NONE;
    if (!busy) begin
      if (cmd_write)        op = OP_WRITE;
      else if (cmd_wrsr)    op = OP_WRSR;
      else if (cmd_clr_wel) op = OP_CLR;
      else if (cmd_set_wel) op = OP_SET;
    end
  end

  assign permit = wel && !busy && !locked;
  assign start  = ((op == OP_WRITE) && permit) || ((op == OP_WRSR) && wel);

endmodule

// File: rtl/stsreg_timer.sv
module stsreg_timer #(
  parameter int CYCLE_CLKS = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic cycle_end
);

  localparam int CNT_W = (CYCLE_CLKS > 1) ? $clog2(CYCLE_CLKS) : 1;

  logic [CNT_W-1:0] remain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      remain_q <= '0;
    end else if (start) begin
      busy     <= 1'b1;
      remain_q <= CNT_W'(CYCLE_CLKS - 1);
    end else if (busy) begin
      if (remain_q == '0) busy <= 1'b0;
      else                remain_q <= remain_q - 1'b1;
    end
  end

  assign cycle_end = busy && (remain_q == '0);

endmodule

// File: rtl/stsreg_regs.sv
module stsreg_regs
  import stsreg_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  op_e        op,
  input  logic       start,
  input  logic       cycle_end,
  input  logic [7:0] wrsr_data,
  output nvbits_t    nv,
  output logic       wel
);

  logic unused_data_bits;
  assign unused_data_bits = ^{wrsr_data[6:4], wrsr_data[1:0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wel <= 1'b0;
    end else if (cycle_end) begin
      wel <= 1'b0;
    end else if (op == OP_SET) begin
      wel <= 1'b1;
    end else if (op == OP_CLR) begin
      wel <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nv <= '0;
    end else if (start && (op == OP_WRSR)) begin
      nv.wpen <= wrsr_data[7];
      nv.bp   <= wrsr_data[3:2];
    end
  end

endmodule

// File: rtl/stsreg_guard.sv
module stsreg_guard
  import stsreg_pkg::*;
#(
  parameter int ADDR_W     = 13,
  parameter int CYCLE_CLKS = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_set_wel,
  input  logic              cmd_clr_wel,
  input  logic              cmd_wrsr,
  input  logic [7:0]        wrsr_data,
  input  logic              cmd_write,
  input  logic [ADDR_W-1:0] write_addr,
  output logic [7:0]        status_byte,
  output logic              busy,
  output logic              wr_permit
);

  localparam int unsigned SPAN = 1 << ADDR_W;

  op_e     op;
  logic    start;
  logic    cycle_end;
  logic    wel_q;
  logic    locked;
  nvbits_t nv_q;

  assign locked = region_locked(nv_q.bp, int'(write_addr), SPAN);

  stsreg_arb u_arb (
    .cmd_set_wel (cmd_set_wel),
    .cmd_clr_wel (cmd_clr_wel),
    .cmd_wrsr    (cmd_wrsr),
    .cmd_write   (cmd_write),
    .busy        (busy),
    .wel         (wel_q),
    .locked      (locked),
    .op          (op),
    .start       (start),
    .permit      (wr_permit)
  );

  stsreg_timer #(.CYCLE_CLKS(CYCLE_CLKS)) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .busy      (busy),
    .cycle_end (cycle_end)
  );

  stsreg_regs u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .op        (op),
    .start     (start),
    .cycle_end (cycle_end),
    .wrsr_data (wrsr_data),
    .nv        (nv_q),
    .wel       (wel_q)
  );

  assign status_byte = status_view(busy, nv_q, wel_q);

endmodule

// File: rtl/stsreg_guard_chk.sv
module stsreg_guard_chk #(
  parameter int CYCLE_CLKS = 64
) (
  input logic       clk,
  input logic       rst_n,
  input logic       cmd_write,
  input logic       busy,
  input logic       wr_permit,
  input logic       wel_q,
  input logic       cycle_end,
  input logic [7:0] status_byte
);

  int unsigned run_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     run_len <= 0;
    else if (!busy) run_len <= 0;
    else            run_len <= run_len + 1;
  end

  a_r5_busy_reads_ones: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> status_byte == 8'hFF);

  a_r6_latch_drops: assert property (@(posedge clk) disable iff (!rst_n)
    cycle_end |=> !wel_q);

  a_r7_reject_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_write && !busy && !wr_permit) |=> (!busy && wel_q == $past(wel_q)));

  a_r9_busy_freezes_latch: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !cycle_end) |=> (busy && $stable(wel_q)));

  a_r4_cycle_length: assert property (@(posedge clk) disable iff (!rst_n)
    cycle_end |-> run_len == CYCLE_CLKS - 1);

  a_r3_permit_needs_latch: assert property (@(posedge clk) disable iff (!rst_n)
    wr_permit |-> (wel_q && !busy));

endmodule

bind stsreg_guard stsreg_guard_chk #(.CYCLE_CLKS(CYCLE_CLKS)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cmd_write   (cmd_write),
  .busy        (busy),
  .wr_permit   (wr_permit),
  .wel_q       (wel_q),
  .cycle_end   (cycle_end),
  .status_byte (status_byte)
);

// File: tb/sim_stsreg_guard.sv
`timescale 1ns/1ps
module sim_stsreg_guard;

  localparam int ADDR_W = 13;
  localparam int CYC    = 4;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              cmd_set_wel = 1'b0, cmd_clr_wel = 1'b0, cmd_wrsr = 1'b0, cmd_write = 1'b0;
  logic [7:0]        wrsr_data = 8'h00;
  logic [ADDR_W-1:0] write_addr = '0;
  logic [7:0]        status_byte;
  logic              busy, wr_permit;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  stsreg_guard #(.ADDR_W(ADDR_W), .CYCLE_CLKS(CYC)) u0 (
    .clk(clk), .rst_n(rst_n), .cmd_set_wel(cmd_set_wel), .cmd_clr_wel(cmd_clr_wel),
    .cmd_wrsr(cmd_wrsr), .wrsr_data(wrsr_data), .cmd_write(cmd_write),
    .write_addr(write_addr), .status_byte(status_byte), .busy(busy), .wr_permit(wr_permit)
  );

  // {bp[1:0], addr[12:0], expected permit}, latch set before each check (R3)
  localparam logic [15:0] VEC [12] = '{
    {2'b00, 13'h0000, 1'b1}, {2'b00, 13'h1FFF, 1'b1},
    {2'b01, 13'h17FF, 1'b1}, {2'b01, 13'h1800, 1'b0},
    {2'b01, 13'h1FFF, 1'b0}, {2'b01, 13'h0000, 1'b1},
    {2'b10, 13'h0FFF, 1'b1}, {2'b10, 13'h1000, 1'b0},
    {2'b10, 13'h1800, 1'b0}, {2'b11, 13'h0000, 1'b0},
    {2'b11, 13'h0ABC, 1'b0}, {2'b11, 13'h1FFF, 1'b0}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // drive one command cycle starting and ending on a falling edge
  task automatic issue(input logic s, input logic c, input logic r, input logic w,
                       input logic [7:0] d, input logic [ADDR_W-1:0] a);
    cmd_set_wel = s; cmd_clr_wel = c; cmd_wrsr = r; cmd_write = w;
    wrsr_data = d; write_addr = a;
    @(negedge clk);
    cmd_set_wel = 0; cmd_clr_wel = 0; cmd_wrsr = 0; cmd_write = 0;
  endtask

  task automatic wait_idle(output int n);
    n = 0;
    while (busy && n < 1000) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic program_bp(input logic [1:0] bp);
    int n;
    issue(1, 0, 0, 0, 8'h00, '0);
    issue(0, 0, 1, 0, {4'b0000, bp, 2'b00}, '0);
    wait_idle(n);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 50000) begin
        errors++;
        $display("FAIL watchdog: actual %0d expected below 50000", cycles);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    int n;
    logic [1:0] cur_bp;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 reset status", status_byte, 8'h00);
    check("R1 reset busy", busy, 0);
    check("R3 permit with latch clear", wr_permit, 0);

    // R2 set and clear, both at once
    issue(1, 0, 0, 0, 8'h00, 13'h0100);
    check("R2 set latch", status_byte, 8'h02);
    issue(0, 1, 0, 0, 8'h00, 13'h0100);
    check("R2 clear latch", status_byte, 8'h00);
    issue(1, 0, 0, 0, 8'h00, 13'h0100);
    issue(1, 1, 0, 0, 8'h00, 13'h0100);
    check("R2 clear wins over set", status_byte, 8'h00);

    // R7 write with latch clear is refused
    issue(0, 0, 0, 1, 8'h00, 13'h0100);
    check("R7 refused write busy", busy, 0);
    check("R7 refused write status", status_byte, 8'h00);

    // R4 R5 R6 accepted write
    issue(1, 0, 0, 0, 8'h00, 13'h0100);
    issue(0, 0, 0, 1, 8'h00, 13'h0100);
    check("R4 busy after accept", busy, 1);
    check("R5 status reads ones", status_byte, 8'hFF);
    wait_idle(n);
    check("R4 busy length", n, CYC);
    check("R6 latch cleared after cycle", status_byte, 8'h00);

    // R9 commands during busy are ignored
    issue(1, 0, 0, 0, 8'h00, 13'h0100);
    issue(0, 0, 0, 1, 8'h00, 13'h0100);
    issue(1, 0, 0, 0, 8'h00, 13'h0100);
    issue(0, 0, 1, 0, 8'h8C, 13'h0100);
    wait_idle(n);
    check("R9 cycle not extended", n, CYC - 2);
    check("R9 busy commands ignored", status_byte, 8'h00);

    // R10 write beats status write
    issue(1, 0, 0, 0, 8'h00, 13'h0100);
    issue(0, 0, 1, 1, 8'h8C, 13'h0100);
    wait_idle(n);
    check("R10 write wins, status untouched", status_byte, 8'h00);
    // R10 status write beats clear
    issue(1, 0, 0, 0, 8'h00, 13'h0100);
    issue(0, 1, 1, 0, 8'h80, 13'h0100);
    check("R10 status write wins over clear", busy, 1);
    wait_idle(n);
    check("R10 status write applied", status_byte, 8'h80);

    // R8 status write without latch refused, unused data bits ignored
    issue(0, 0, 1, 0, 8'h0C, 13'h0000);
    check("R8 status write needs latch", busy, 0);
    check("R8 status unchanged", status_byte, 8'h80);
    issue(1, 0, 0, 0, 8'h00, 13'h0000);
    issue(0, 0, 1, 0, 8'h73, 13'h0000);
    wait_idle(n);
    check("R8 length", n, CYC);
    check("R8 unused bits ignored", status_byte, 8'h00);

    // R3 protection table
    cur_bp = 2'b00;
    for (int i = 0; i < 12; i++) begin
      if (VEC[i][15:14] != cur_bp) begin
        cur_bp = VEC[i][15:14];
        program_bp(cur_bp);
      end
      issue(1, 0, 0, 0, 8'h00, VEC[i][13:1]);
      check($sformatf("R1 status bp=%0d", cur_bp), status_byte, {4'b0000, cur_bp, 2'b10});
      #1;
      check($sformatf("R3 permit bp=%0d addr=%0h", cur_bp, VEC[i][13:1]),
            wr_permit, VEC[i][0]);
    end

    // R7 protected write refused, latch kept; R8 status write ignores protection
    issue(0, 0, 0, 1, 8'h00, 13'h0020);
    check("R7 protected write no busy", busy, 0);
    check("R7 latch kept", status_byte, 8'h0E);
    issue(0, 0, 1, 0, 8'h00, 13'h1FFF);
    check("R8 status write under full protection", busy, 1);
    wait_idle(n);
    check("R8 protection cleared", status_byte, 8'h00);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule